// File: doc/BRIEF.md
# Flash Programming Loop Sequencer

This block runs on the host side and writes a run of consecutive words into a parallel NOR-style flash device. A request names a base address, a word count and whether the shortened bypass command form is used. For each address the block fetches the word from a data source and writes the program command cycles followed by the word. It then reads status from the target address until the device reports that its internal program operation has finished. After that it reads the word back once and compares it against the intended value.

The flash bus is modelled with single-clock strobes. A write strobe carries an address and a data word. A read strobe carries an address, and the device must present the read word on the following clock, where the sequencer samples it. The end of a run is reported with a one-clock pulse: either success, or an error that also gives the failing address and the cause.

Top module: `flash_prog_seq`

## Requirements
- R1: With bypass off, every word is written as four strobed writes in this order: 0xAA to address 0x555, 0x55 to address 0x2AA, 0xA0 to address 0x555, and then the word to its target address. Command bytes sit in data bits 7:0.
- R2: With bypass on (sampled at start), every word uses two writes: 0xA0 to the target address, then the word to the same address.
- R3: After the word write, status reads are issued to the target address. They repeat until bit 7 of the read value equals bit 7 of the intended word.
- R4: After the status reads finish, exactly one verify read of the target address is issued, and all bits are compared with the intended word.
- R5: Words are programmed at base, base+1, … base+len-1, in ascending order. After the last successful verify, done_o pulses for one clock and busy_o returns low. No address past the run is written.
- R6: A verify mismatch ends the run with a one-clock err_o pulse. It sets err_addr_o to the failing address and err_timeout_o to 0, and no further writes follow.
- R7: If POLL_LIMIT status reads all report that the device is still busy, the run ends with an err_o pulse, err_timeout_o set to 1 and err_addr_o set to that address. Exactly POLL_LIMIT status reads are issued for that word.
- R8: A start while busy_o is high is ignored. No word of the ignored request is written, and the current run completes unchanged.
- R9: A start with len_i equal to 0 gives a done_o pulse on the next clock and causes no bus cycle.
- R10: After reset, busy_o, done_o, err_o, fl_we_o and fl_re_o are all low.
- R11: fl_we_o and fl_re_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, taken only while idle |
| base_i | input | AW | First target address |
| len_i | input | AW | Number of words to program |
| bypass_i | input | 1 | Use the two-write command form |
| src_addr_o | output | AW | Address whose word is wanted from the source |
| src_data_i | input | DW | Source word for src_addr_o |
| fl_addr_o | output | AW | Flash bus address |
| fl_wdata_o | output | DW | Flash bus write data |
| fl_rdata_i | input | DW | Flash read data, valid the clock after fl_re_o |
| fl_we_o | output | 1 | Write strobe, one clock per bus write |
| fl_re_o | output | 1 | Read strobe, one clock per bus read |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-clock pulse when a run completes |
| err_o | output | 1 | One-clock pulse when a run aborts |
| err_addr_o | output | AW | Address of the word that aborted the run |
| err_timeout_o | output | 1 | 1 if the abort was a status timeout, 0 if it was a verify mismatch |

## Verification
The assertions assume a device that answers every read strobe on the next clock. They also assume that len_i plus base_i does not wrap the address space and that src_data_i is stable while its address is shown. The bench flash model meets these assumptions by registering its read data one clock after the strobe. The bench keeps every run inside a 256-word window, and it derives the source word combinationally from src_addr_o. Status latency is set per run. Runs that should time out use a latency above POLL_LIMIT, and all other runs stay well below it.

// File: rtl/fps_pkg.sv
package fps_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CMD,
    ST_POLL_RD,
    ST_POLL_WT,
    ST_VER_RD,
    ST_VER_WT
  } fps_state_e;

  localparam logic [7:0]  KEY_FIRST  = 8'hAA;
  localparam logic [7:0]  KEY_SECOND = 8'h55;
  localparam logic [7:0]  KEY_PROG   = 8'hA0;
  localparam logic [11:0] KEY_ADR_HI = 12'h555;
  localparam logic [11:0] KEY_ADR_LO = 12'h2AA;

  // index of the write step that carries the payload word
  function automatic logic [1:0] payload_step(input logic bypass);
    return bypass ? 2'd1 : 2'd3;
  endfunction

  // status bit 7 mirrors the payload once the device has finished
  function automatic logic status_settled(input logic [7:0] status, input logic [7:0] want);
    return status[7] == want[7];
  endfunction

endpackage

// File: rtl/fps_cmd_gen.sv
module fps_cmd_gen #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          bypass_i,
  input  logic [1:0]    step_i,
  input  logic [AW-1:0] tgt_addr_i,
  input  logic [DW-1:0] tgt_data_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic          last_o
);
  import fps_pkg::*;

  assign last_o = (step_i == payload_step(bypass_i));

  always_comb begin
    addr_o = tgt_addr_i;
    data_o = tgt_data_i;
    if (bypass_i) begin
      if (step_i == 2'd0) data_o = DW'(KEY_PROG);
    end else begin
      unique case (step_i)
        2'd0: begin addr_o = AW'(KEY_ADR_HI); data_o = DW'(KEY_FIRST);  end
        2'd1: begin addr_o = AW'(KEY_ADR_LO); data_o = DW'(KEY_SECOND); end
        2'd2: begin addr_o = AW'(KEY_ADR_HI); data_o = DW'(KEY_PROG);   end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/fps_poll_unit.sv
module fps_poll_unit #(
  parameter int DW         = 16,
  parameter int POLL_LIMIT = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          smp_i,
  input  logic [DW-1:0] rdata_i,
  input  logic [DW-1:0] want_i,
  output logic          hit_o,
  output logic          expire_o
);
  import fps_pkg::*;

  localparam int CW = $clog2(POLL_LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign hit_o    = smp_i && status_settled(rdata_i[7:0], want_i[7:0]);
  assign expire_o = smp_i && !hit_o && (cnt_q == CW'(POLL_LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (smp_i && !hit_o) cnt_q <= cnt_q + 1'b1;
  end

  p_poll_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_i |-> (cnt_q < CW'(POLL_LIMIT)));

endmodule

// File: rtl/fps_addr_walk.sv
module fps_addr_walk #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] len_i,
  input  logic          adv_i,
  output logic [AW-1:0] cur_addr_o,
  output logic          last_o
);
  logic [AW-1:0] base_q, len_q, off_q;

  assign cur_addr_o = base_q + off_q;
  assign last_o     = (off_q + 1'b1) == len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
      off_q  <= '0;
    end else if (load_i) begin
      base_q <= base_i;
      len_q  <= len_i;
      off_q  <= '0;
    end else if (adv_i) begin
      off_q  <= off_q + 1'b1;
    end
  end

  p_len_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(len_q));

  p_off_in_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q != '0) |-> (off_q < len_q));

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq #(
  parameter int AW         = 12,
  parameter int DW         = 16,
  parameter int POLL_LIMIT = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] len_i,
  input  logic          bypass_i,
  output logic [AW-1:0] src_addr_o,
  input  logic [DW-1:0] src_data_i,
  output logic [AW-1:0] fl_addr_o,
  output logic [DW-1:0] fl_wdata_o,
  input  logic [DW-1:0] fl_rdata_i,
  output logic          fl_we_o,
  output logic          fl_re_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [AW-1:0] err_addr_o,
  output logic          err_timeout_o
);
  import fps_pkg::*;

  fps_state_e    state_q;
  logic [1:0]    step_q;
  logic          byp_q;
  logic [DW-1:0] word_q;
  logic          done_q, err_q, err_to_q;
  logic [AW-1:0] err_addr_q;

  // named events for the checks
  logic          accept_ev, empty_ev, poll_clr_ev, poll_smp_ev, verify_ok_ev, verify_bad_ev;
  logic          poll_hit, poll_expire;
  logic          walk_last;
  logic [AW-1:0] cur_addr;
  logic [AW-1:0] gen_addr;
  logic [DW-1:0] gen_data;
  logic          gen_last;

  assign accept_ev     = (state_q == ST_IDLE) && start_i;
  assign empty_ev      = accept_ev && (len_i == '0);
  assign poll_clr_ev   = (state_q == ST_CMD) && gen_last;
  assign poll_smp_ev   = (state_q == ST_POLL_WT);
  assign verify_ok_ev  = (state_q == ST_VER_WT) && (fl_rdata_i == word_q);
  assign verify_bad_ev = (state_q == ST_VER_WT) && (fl_rdata_i != word_q);

  fps_addr_walk #(.AW(AW)) walk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (accept_ev),
    .base_i     (base_i),
    .len_i      (len_i),
    .adv_i      (verify_ok_ev && !walk_last),
    .cur_addr_o (cur_addr),
    .last_o     (walk_last)
  );

  fps_cmd_gen #(.AW(AW), .DW(DW)) gen_i (
    .bypass_i   (byp_q),
    .step_i     (step_q),
    .tgt_addr_i (cur_addr),
    .tgt_data_i (word_q),
    .addr_o     (gen_addr),
    .data_o     (gen_data),
    .last_o     (gen_last)
  );

  fps_poll_unit #(.DW(DW), .POLL_LIMIT(POLL_LIMIT)) poll_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (poll_clr_ev),
    .smp_i    (poll_smp_ev),
    .rdata_i  (fl_rdata_i),
    .want_i   (word_q),
    .hit_o    (poll_hit),
    .expire_o (poll_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      step_q     <= '0;
      byp_q      <= 1'b0;
      word_q     <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      err_to_q   <= 1'b0;
      err_addr_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (empty_ev) begin
            done_q <= 1'b1;
          end else if (accept_ev) begin
            byp_q   <= bypass_i;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          word_q  <= src_data_i;
          step_q  <= '0;
          state_q <= ST_CMD;
        end
        ST_CMD: begin
          if (gen_last) state_q <= ST_POLL_RD;
          else          step_q  <= step_q + 1'b1;
        end
        ST_POLL_RD: state_q <= ST_POLL_WT;
        ST_POLL_WT: begin
          if (poll_hit) begin
            state_q <= ST_VER_RD;
          end else if (poll_expire) begin
            err_q      <= 1'b1;
            err_to_q   <= 1'b1;
            err_addr_q <= cur_addr;
            state_q    <= ST_IDLE;
          end else begin
            state_q <= ST_POLL_RD;
          end
        end
        ST_VER_RD: state_q <= ST_VER_WT;
        ST_VER_WT: begin
          if (verify_bad_ev) begin
            err_q      <= 1'b1;
            err_to_q   <= 1'b0;
            err_addr_q <= cur_addr;
            state_q    <= ST_IDLE;
          end else if (walk_last) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_FETCH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    fl_we_o    = (state_q == ST_CMD);
    fl_re_o    = (state_q == ST_POLL_RD) || (state_q == ST_VER_RD);
    fl_addr_o  = fl_we_o ? gen_addr : cur_addr;
    fl_wdata_o = fl_we_o ? gen_data : '0;
  end

  assign src_addr_o    = cur_addr;
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = done_q;
  assign err_o         = err_q;
  assign err_addr_o    = err_addr_q;
  assign err_timeout_o = err_to_q;

  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we_o && fl_re_o));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_err_ends_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!busy_o && !done_o));

  p_verify_follows_poll_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_re_o && $past(poll_hit)) |-> (fl_addr_o == $past(cur_addr)));

endmodule

// File: tb/flash_prog_seq_tb_top.sv
module flash_prog_seq_tb_top;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int LIM = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] base = '0, len = '0;
  logic byp = 1'b0;
  logic [AW-1:0] src_addr, fl_addr, err_addr;
  logic [DW-1:0] src_data, fl_wdata;
  logic [DW-1:0] rdata_q = '0;
  logic fl_we, fl_re, busy, done, err, err_to;

  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return ((16'(a) * 16'h03B1) ^ 16'h5A5A) | 16'h0001;
  endfunction

  assign src_data = pat(src_addr);

  flash_prog_seq #(.AW(AW), .DW(DW), .POLL_LIMIT(LIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .base_i(base), .len_i(len),
    .bypass_i(byp), .src_addr_o(src_addr), .src_data_i(src_data),
    .fl_addr_o(fl_addr), .fl_wdata_o(fl_wdata), .fl_rdata_i(rdata_q),
    .fl_we_o(fl_we), .fl_re_o(fl_re), .busy_o(busy), .done_o(done),
    .err_o(err), .err_addr_o(err_addr), .err_timeout_o(err_to)
  );

  // flash device model
  logic [DW-1:0] mem [0:255];
  bit byp_mode;
  int step, lat_cfg, busy_left, proto_err, n_wr, n_rd, n_busy_rd, n_done, n_err;
  logic [DW-1:0] prog_d;

  always @(posedge clk) begin
    if (done) n_done++;
    if (err)  n_err++;
    if (fl_we) begin
      n_wr++;
      if (byp_mode) begin
        if (step == 0) begin
          if (fl_wdata[7:0] == 8'hA0) step = 1; else proto_err++;
        end else begin
          mem[fl_addr[7:0]] = mem[fl_addr[7:0]] & fl_wdata;
          prog_d = fl_wdata; busy_left = lat_cfg; step = 0;
        end
      end else begin
        case (step)
          0: if (fl_addr[10:0] == 11'h555 && fl_wdata[7:0] == 8'hAA) step = 1; else begin proto_err++; step = 0; end
          1: if (fl_addr[10:0] == 11'h2AA && fl_wdata[7:0] == 8'h55) step = 2; else begin proto_err++; step = 0; end
          2: if (fl_addr[10:0] == 11'h555 && fl_wdata[7:0] == 8'hA0) step = 3; else begin proto_err++; step = 0; end
          default: begin
            mem[fl_addr[7:0]] = mem[fl_addr[7:0]] & fl_wdata;
            prog_d = fl_wdata; busy_left = lat_cfg; step = 0;
          end
        endcase
      end
    end
    if (fl_re) begin
      n_rd++;
      if (busy_left > 0) begin
        busy_left--; n_busy_rd++;
        rdata_q <= {8'h00, ~prog_d[7], 7'h00};
      end else begin
        rdata_q <= mem[fl_addr[7:0]];
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
    step = 0; busy_left = 0; proto_err = 0; n_wr = 0; n_rd = 0;
    n_busy_rd = 0; n_done = 0; n_err = 0;
  endtask

  bit saw_done, saw_err;

  task automatic run(input int b, input int l, input bit bp, input int lat, input int mid_at);
    int cyc;
    lat_cfg = lat; byp_mode = bp;
    @(negedge clk);
    start = 1'b1; base = AW'(b); len = AW'(l); byp = bp;
    @(negedge clk);
    start = 1'b0;
    cyc = 0; saw_done = 0; saw_err = 0;
    while (!(done || err) && cyc < 5000) begin
      if (cyc == mid_at) begin
        start = 1'b1; base = AW'(200); len = AW'(3); byp = ~bp;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    saw_done = done; saw_err = err;
    @(negedge clk);
    check(!done && !err && !busy, "R5 pulse one clock then idle", {done, err, busy}, 0);
  endtask

  initial begin
    model_reset();
    #1;
    check(!busy && !done && !err && !fl_we && !fl_re, "R10 reset state",
          {busy, done, err, fl_we, fl_re}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(!busy && !fl_we && !fl_re, "R10 idle after reset", {busy, fl_we, fl_re}, 0);

    // sweep of lengths, both command forms, two latencies
    for (int bp = 0; bp < 2; bp++)
      for (int l = 1; l <= 6; l++)
        for (int li = 0; li < 2; li++) begin
          int b = 10 + (l - 1) * 30 + bp * 7;
          int lat = li * 3;
          model_reset();
          run(b, l, bit'(bp), lat, -1);
          check(saw_done && !saw_err, "R5 run ends with done", {saw_done, saw_err}, 2);
          check(n_done == 1, "R5 single done pulse", n_done, 1);
          check(proto_err == 0, bp ? "R2 bypass command order" : "R1 unlock command order", proto_err, 0);
          check(n_wr == l * (bp ? 2 : 4), bp ? "R2 two writes per word" : "R1 four writes per word",
                n_wr, l * (bp ? 2 : 4));
          check(n_rd == l * (lat + 2), "R3 R4 status plus one verify read per word", n_rd, l * (lat + 2));
          for (int i = 0; i < l; i++)
            check(mem[b + i] == pat(AW'(b + i)), "R5 word programmed", mem[b + i], pat(AW'(b + i)));
          check(mem[b + l] == 16'hFFFF, "R5 no write past run", mem[b + l], 16'hFFFF);
        end

    // verify mismatch at third word, bypass form
    model_reset();
    mem[62] = 16'hFFFE;
    run(60, 5, 1'b1, 1, -1);
    check(saw_err && !saw_done, "R6 mismatch aborts", {saw_err, saw_done}, 2);
    check(err_addr == AW'(62), "R6 failing address", err_addr, 62);
    check(err_to == 1'b0, "R6 cause is mismatch", err_to, 0);
    check(n_wr == 6, "R6 no writes after abort", n_wr, 6);
    check(mem[63] == 16'hFFFF, "R6 next word untouched", mem[63], 16'hFFFF);

    // status never settles
    model_reset();
    run(100, 3, 1'b0, 20, -1);
    check(saw_err, "R7 timeout aborts", saw_err, 1);
    check(err_to == 1'b1, "R7 cause is timeout", err_to, 1);
    check(err_addr == AW'(100), "R7 failing address", err_addr, 100);
    check(n_busy_rd == LIM, "R7 exact status read count", n_busy_rd, LIM);
    check(n_wr == 4, "R7 stopped at first word", n_wr, 4);

    // zero length
    model_reset();
    run(30, 0, 1'b0, 0, -1);
    check(saw_done && !saw_err, "R9 empty run done", {saw_done, saw_err}, 2);
    check(n_wr == 0 && n_rd == 0, "R9 no bus cycles", n_wr + n_rd, 0);

    // start while busy is ignored
    model_reset();
    run(40, 4, 1'b0, 2, 9);
    check(saw_done && n_done == 1, "R8 original run completes once", n_done, 1);
    check(n_wr == 16, "R8 write count unchanged", n_wr, 16);
    check(proto_err == 0, "R8 command order kept", proto_err, 0);
    for (int i = 0; i < 4; i++)
      check(mem[40 + i] == pat(AW'(40 + i)), "R8 original words", mem[40 + i], pat(AW'(40 + i)));
    for (int i = 0; i < 3; i++)
      check(mem[200 + i] == 16'hFFFF, "R8 ignored request untouched", mem[200 + i], 16'hFFFF);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_tests++; n_fail++;
      $display("FAIL R5 watchdog expired actual=%0d expected=%0d", wd, 150000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule